// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit picks the next fetch address for a simple in-order pipeline and settles every control-flow change while the instruction sits in decode. It combines the fetch-stage PC, the decoded instruction's class, PC and immediate field, and the register-file read data. From these it forms four candidate addresses: the sequential fetch PC+4, an absolute jump target, a register-indirect target and a PC-relative branch target. A four-way multiplexer then picks one of them.

The branch condition is a zero test placed directly on the register-file read data. Because of this, a conditional branch is settled in decode and costs one bubble, the same as an unconditional jump. Whenever control is redirected, the unit raises a kill signal. The pipeline uses it to turn the instruction already fetched behind the redirecting one into a NOP. The unit is purely combinational. The fetch PC register, the instruction memory and the register file stay outside it.

Top module: `bru_decode_resolve`

## Requirements
- R1: When the decode instruction causes no control-flow change, `next_pc_o` equals `fetch_pc_i + 4` and `kill_o` is 0. This covers class code 3'b000 (ALU) and the unused codes 3'b001, 3'b110 and 3'b111.
- R2: Class code 3'b010 is a direct jump. Its target is bits [31:28] of `dec_pc_i + 4`, followed by `dec_imm_i[25:0]`, followed by two zero bits. `kill_o` is 1.
- R3: Class code 3'b011 is a jump-register. `next_pc_o` equals `rs_data_i` unchanged, and `kill_o` is 1.
- R4: The target of a taken branch is `dec_pc_i + 4 + (sign-extended dec_imm_i[15:0] << 2)`, computed modulo 2^32. Bits [25:16] of `dec_imm_i` do not affect it.
- R5: Class codes 3'b100 and 3'b101 are conditional branches, and bit 0 of the code selects the flavour. Code 3'b100 is taken exactly when `rs_data_i` is all zeros. Code 3'b101 is taken exactly when `rs_data_i` is not all zeros. A branch that is not taken behaves as in R1.
- R6: While `dec_stall_i` is 1, no redirect is issued: `next_pc_o` is `fetch_pc_i + 4` and `kill_o` is 0, whatever the class code.
- R7: While `dec_valid_i` is 0, the decode slot holds a bubble and is ignored: `next_pc_o` is `fetch_pc_i + 4` and `kill_o` is 0.
- R8: `kill_o` is 1 exactly when a jump, a jump-register or a taken branch is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_pc_i | input | 32 | PC of the instruction currently in fetch |
| dec_valid_i | input | 1 | Decode slot holds a real instruction |
| dec_stall_i | input | 1 | Decode is held this cycle |
| dec_op_i | input | 3 | Control-flow class of the decode instruction |
| dec_pc_i | input | 32 | PC of the decode instruction |
| dec_imm_i | input | 26 | Jump index, or branch word offset in the low 16 bits |
| rs_data_i | input | 32 | Register-file read data for the branch or jump-register source |
| next_pc_o | output | 32 | Selected next fetch address |
| kill_o | output | 1 | Replace the instruction in fetch with a NOP |

## Verification
The hardest cases to reach from the ports are the condition edge cases. One is a register value that differs from zero in a single bit, tested under both branch flavours. Another is a branch offset that wraps the address space or carries into the region bits used by a jump. Uniform random register data almost never produces zero. The stimulus therefore forces zero in about a quarter of the random vectors and adds directed one-hot register values. It also adds directed extreme offsets next to PCs near the top and bottom of memory. Stall and bubble are applied together with redirecting classes, to show that they block the kill.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OPC_ALU  = 3'b000;
  localparam logic [OP_W-1:0] OPC_JUMP = 3'b010;
  localparam logic [OP_W-1:0] OPC_JREG = 3'b011;
  localparam logic [OP_W-1:0] OPC_BRZ  = 3'b100;
  localparam logic [OP_W-1:0] OPC_BRNZ = 3'b101;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_JABS = 2'd1,
    SRC_RIND = 2'd2,
    SRC_BR   = 2'd3
  } pc_src_e;
endpackage

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 26,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  fetch_pc_i,
  input  logic [XLEN-1:0]  dec_pc_i,
  input  logic [IDX_W-1:0] imm_i,
  output logic [XLEN-1:0]  seq_pc_o,
  output logic [XLEN-1:0]  jabs_pc_o,
  output logic [XLEN-1:0]  br_pc_o
);
  localparam int unsigned REGION_W = XLEN - IDX_W - 2;
  localparam int unsigned EXT_W    = XLEN - OFF_W;

  logic [XLEN-1:0] dec_link;
  logic [XLEN-1:0] off_ext;

  assign seq_pc_o  = fetch_pc_i + XLEN'(4);
  assign dec_link  = dec_pc_i + XLEN'(4);
  assign jabs_pc_o = {dec_link[XLEN-1 -: REGION_W], imm_i, 2'b00};
  assign off_ext   = {{EXT_W{imm_i[OFF_W-1]}}, imm_i[OFF_W-1:0]};
  assign br_pc_o   = dec_link + (off_ext << 2);
endmodule

// File: rtl/bru_zero_det.sv
module bru_zero_det #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] data_i,
  output logic            is_zero_o
);
  assign is_zero_o = ~|data_i;
endmodule

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic            valid_i,
  input  logic            stall_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            is_zero_i,
  output pc_src_e         src_o,
  output logic            kill_o
);
  logic is_branch;
  logic br_taken;

  assign is_branch = (op_i[OP_W-1 -: 2] == OPC_BRZ[OP_W-1 -: 2]);
  // op bit 0 flips the sense: 0 = taken on zero, 1 = taken on non-zero
  assign br_taken  = is_zero_i ^ op_i[0];

  always_comb begin
    src_o = SRC_SEQ;
    if (valid_i && !stall_i) begin
      if (op_i == OPC_JUMP)            src_o = SRC_JABS;
      else if (op_i == OPC_JREG)       src_o = SRC_RIND;
      else if (is_branch && br_taken)  src_o = SRC_BR;
    end
  end

  assign kill_o = (src_o != SRC_SEQ);
endmodule

// File: rtl/bru_pc_mux.sv
module bru_pc_mux
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  pc_src_e         src_i,
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] jabs_pc_i,
  input  logic [XLEN-1:0] rind_pc_i,
  input  logic [XLEN-1:0] br_pc_i,
  output logic [XLEN-1:0] pc_o
);
  always_comb begin
    unique case (src_i)
      SRC_JABS: pc_o = jabs_pc_i;
      SRC_RIND: pc_o = rind_pc_i;
      SRC_BR:   pc_o = br_pc_i;
      default:  pc_o = seq_pc_i;
    endcase
  end
endmodule

// File: rtl/bru_decode_resolve.sv
module bru_decode_resolve
  import bru_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 26,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  fetch_pc_i,
  input  logic             dec_valid_i,
  input  logic             dec_stall_i,
  input  logic [OP_W-1:0]  dec_op_i,
  input  logic [XLEN-1:0]  dec_pc_i,
  input  logic [IDX_W-1:0] dec_imm_i,
  input  logic [XLEN-1:0]  rs_data_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             kill_o
);
  logic [XLEN-1:0] seq_pc, jabs_pc, br_pc;
  logic            rs_zero;
  pc_src_e         pc_src;

  bru_target_gen #(.XLEN(XLEN), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_tgt (
    .fetch_pc_i(fetch_pc_i),
    .dec_pc_i  (dec_pc_i),
    .imm_i     (dec_imm_i),
    .seq_pc_o  (seq_pc),
    .jabs_pc_o (jabs_pc),
    .br_pc_o   (br_pc)
  );

  bru_zero_det #(.XLEN(XLEN)) u_zero (
    .data_i   (rs_data_i),
    .is_zero_o(rs_zero)
  );

  bru_ctrl u_ctrl (
    .valid_i  (dec_valid_i),
    .stall_i  (dec_stall_i),
    .op_i     (dec_op_i),
    .is_zero_i(rs_zero),
    .src_o    (pc_src),
    .kill_o   (kill_o)
  );

  bru_pc_mux #(.XLEN(XLEN)) u_mux (
    .src_i    (pc_src),
    .seq_pc_i (seq_pc),
    .jabs_pc_i(jabs_pc),
    .rind_pc_i(rs_data_i),
    .br_pc_i  (br_pc),
    .pc_o     (next_pc_o)
  );
endmodule

// File: rtl/bru_decode_resolve_chk.sv
module bru_decode_resolve_chk
  import bru_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 26
) (
  input logic [XLEN-1:0]  fetch_pc_i,
  input logic             dec_valid_i,
  input logic             dec_stall_i,
  input logic [OP_W-1:0]  dec_op_i,
  input logic [XLEN-1:0]  dec_pc_i,
  input logic [IDX_W-1:0] dec_imm_i,
  input logic [XLEN-1:0]  rs_data_i,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             kill_o
);
  logic live;
  assign live = dec_valid_i && !dec_stall_i;

  always_comb begin
    a_r1_quiet_is_sequential: assert (kill_o || next_pc_o == fetch_pc_i + XLEN'(4))
      else $error("next PC not sequential without kill");
    a_r6_stall_blocks_kill: assert (!(dec_stall_i && kill_o))
      else $error("kill while decode stalled");
    a_r7_bubble_blocks_kill: assert (!(!dec_valid_i && kill_o))
      else $error("kill from a bubble");
    a_r3_jreg_target: assert (!(live && dec_op_i == OPC_JREG) || (kill_o && next_pc_o == rs_data_i))
      else $error("jump-register target wrong");
    a_r2_jump_kills: assert (!(live && dec_op_i == OPC_JUMP) ||
                             (kill_o && next_pc_o[IDX_W+1:0] == {dec_imm_i, 2'b00}))
      else $error("direct jump not redirected");
    a_r5_brz_zero_taken: assert (!(live && dec_op_i == OPC_BRZ && rs_data_i == '0) || kill_o)
      else $error("branch-if-zero not taken on zero");
    a_r5_brnz_zero_fallthru: assert (!(live && dec_op_i == OPC_BRNZ && rs_data_i == '0) || !kill_o)
      else $error("branch-if-not-zero taken on zero");
    a_r8_alu_no_kill: assert (!(dec_op_i == OPC_ALU && kill_o))
      else $error("kill for a non-control instruction");
  end
endmodule

bind bru_decode_resolve bru_decode_resolve_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .fetch_pc_i (fetch_pc_i),
  .dec_valid_i(dec_valid_i),
  .dec_stall_i(dec_stall_i),
  .dec_op_i   (dec_op_i),
  .dec_pc_i   (dec_pc_i),
  .dec_imm_i  (dec_imm_i),
  .rs_data_i  (rs_data_i),
  .next_pc_o  (next_pc_o),
  .kill_o     (kill_o)
);

// File: tb/bru_decode_resolve_tb.sv
module bru_decode_resolve_tb;
  logic        clk = 1'b0;
  logic [31:0] fetch_pc;
  logic        dec_valid;
  logic        dec_stall;
  logic [2:0]  dec_op;
  logic [31:0] dec_pc;
  logic [25:0] dec_imm;
  logic [31:0] rs_data;
  logic [31:0] next_pc;
  logic        kill;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bru_decode_resolve u_dut (
    .fetch_pc_i (fetch_pc),
    .dec_valid_i(dec_valid),
    .dec_stall_i(dec_stall),
    .dec_op_i   (dec_op),
    .dec_pc_i   (dec_pc),
    .dec_imm_i  (dec_imm),
    .rs_data_i  (rs_data),
    .next_pc_o  (next_pc),
    .kill_o     (kill)
  );

  // reference model: {kill, next_pc}
  function automatic logic [32:0] ref_model(
    input logic [31:0] fpc, input logic v, input logic s, input logic [2:0] op,
    input logic [31:0] dpc, input logic [25:0] imm, input logic [31:0] rs);
    logic [31:0] seq, link, tgt, off;
    logic        take;
    seq  = fpc + 32'd4;
    link = dpc + 32'd4;
    take = 1'b0;
    tgt  = seq;
    if (v && !s) begin
      case (op)
        3'b010: begin take = 1'b1; tgt = {link[31:28], imm, 2'b00}; end
        3'b011: begin take = 1'b1; tgt = rs; end
        3'b100, 3'b101: begin
          take = (op == 3'b100) ? (rs == 32'd0) : (rs != 32'd0);
          off  = {{16{imm[15]}}, imm[15:0]};
          if (take) tgt = link + {off[29:0], 2'b00};
        end
        default: ;
      endcase
    end
    return {take, tgt};
  endfunction

  task automatic apply(input string tag, input logic [31:0] fpc, input logic v, input logic s,
                       input logic [2:0] op, input logic [31:0] dpc, input logic [25:0] imm,
                       input logic [31:0] rs);
    logic [32:0] exp;
    @(negedge clk);
    fetch_pc = fpc; dec_valid = v; dec_stall = s; dec_op = op;
    dec_pc = dpc; dec_imm = imm; rs_data = rs;
    #1;
    exp = ref_model(fpc, v, s, op, dpc, imm, rs);
    n_vec++;
    if ({kill, next_pc} !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d got kill=%0b pc=%08h, expected kill=%0b pc=%08h",
               tag, op, kill, next_pc, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    fetch_pc = '0; dec_valid = 1'b0; dec_stall = 1'b0; dec_op = '0;
    dec_pc = '0; dec_imm = '0; rs_data = '0;
    void'($urandom(32'd2024));

    // idle state, R7 bubble
    apply("R7", 32'h0000_0000, 1'b0, 1'b0, 3'b000, 32'h0, 26'h0, 32'h0);
    // R1 ALU and unused codes
    apply("R1", 32'h0000_1000, 1'b1, 1'b0, 3'b000, 32'h0000_0ffc, 26'h3ff_ffff, 32'h0);
    apply("R1", 32'h0000_2000, 1'b1, 1'b0, 3'b001, 32'h0000_1ffc, 26'h123_4567, 32'h0);
    apply("R1", 32'h0000_3000, 1'b1, 1'b0, 3'b110, 32'h0000_2ffc, 26'h0, 32'h0);
    apply("R1", 32'hffff_fffc, 1'b1, 1'b0, 3'b111, 32'h0, 26'h0, 32'h5);
    // R2 direct jump; region taken from dec_pc+4 that carries into bit 28
    apply("R2", 32'h1000_0004, 1'b1, 1'b0, 3'b010, 32'h1000_0000, 26'h000_0040, 32'h0);
    apply("R2", 32'h1000_0000, 1'b1, 1'b0, 3'b010, 32'h0fff_fffc, 26'h3ff_ffff, 32'h0);
    apply("R8", 32'h8000_0000, 1'b1, 1'b0, 3'b010, 32'hf000_0000, 26'h0, 32'h0);
    // R3 jump register, unaligned value passes unchanged
    apply("R3", 32'h0000_4000, 1'b1, 1'b0, 3'b011, 32'h0000_3ffc, 26'h0, 32'hdead_beef);
    apply("R3", 32'h0000_4000, 1'b1, 1'b0, 3'b011, 32'h0000_3ffc, 26'h0, 32'h0);
    // R5 flavours around zero, one-hot register values
    apply("R5", 32'h0000_0104, 1'b1, 1'b0, 3'b100, 32'h0000_0100, 26'h000_0010, 32'h0);
    apply("R5", 32'h0000_0104, 1'b1, 1'b0, 3'b100, 32'h0000_0100, 26'h000_0010, 32'h8000_0000);
    apply("R5", 32'h0000_0104, 1'b1, 1'b0, 3'b101, 32'h0000_0100, 26'h000_0010, 32'h0);
    apply("R5", 32'h0000_0104, 1'b1, 1'b0, 3'b101, 32'h0000_0100, 26'h000_0010, 32'h0000_0001);
    // R4 offsets: negative, wrap low, wrap high, upper imm bits ignored
    apply("R4", 32'h0000_0104, 1'b1, 1'b0, 3'b100, 32'h0000_0100, 26'h000_ffff, 32'h0);
    apply("R4", 32'h0000_0004, 1'b1, 1'b0, 3'b100, 32'h0000_0000, 26'h000_8000, 32'h0);
    apply("R4", 32'h0000_0000, 1'b1, 1'b0, 3'b101, 32'hffff_fffc, 26'h000_7fff, 32'h1);
    apply("R4", 32'h0000_0204, 1'b1, 1'b0, 3'b100, 32'h0000_0200, 26'h3ff_0003, 32'h0);
    // R6 stall blocks every redirecting class
    apply("R6", 32'h0000_5000, 1'b1, 1'b1, 3'b010, 32'h0000_4ffc, 26'h1, 32'h0);
    apply("R6", 32'h0000_5000, 1'b1, 1'b1, 3'b011, 32'h0000_4ffc, 26'h1, 32'h1234_5678);
    apply("R6", 32'h0000_5000, 1'b1, 1'b1, 3'b100, 32'h0000_4ffc, 26'h1, 32'h0);
    // R7 bubble with redirecting classes
    apply("R7", 32'h0000_6000, 1'b0, 1'b0, 3'b010, 32'h0000_5ffc, 26'h1, 32'h0);
    apply("R7", 32'h0000_6000, 1'b0, 1'b0, 3'b101, 32'h0000_5ffc, 26'h1, 32'h7);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rs;
      rs = ($urandom_range(3) == 0) ? 32'h0 : $urandom;
      apply("R8", $urandom & 32'hffff_fffc,
            ($urandom_range(7) != 0), ($urandom_range(7) == 0),
            3'($urandom_range(7)), $urandom & 32'hffff_fffc, 26'($urandom), rs);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got done=0 expected done=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule